// File: doc/BRIEF.md
# DRAM Row/Column Access Sequencer

This block runs a single DRAM access for each high phase of a slow system bus clock. A fast dot clock paces the steps. The bus clock is treated as a plain level and sampled in the dot-clock domain. A rising bus clock with a pending request starts the access. The sequencer then walks through a fixed series of steps, one per dot-clock edge: it presents the row half of the address, strobes the row, switches to the column half, strobes the column, holds for one step and releases everything. All of this finishes before the bus clock falls.

A merge input lets the row strobe fall in the same step that the column address appears. This removes one step from the sequence and leaves more time for slower parts. On writes, the data bus is driven and the write strobe falls along with the column address. On reads, a one-step capture pulse marks the moment to register the read data, while the column strobe is still low.

Top module: `dram_step_seq`

## Requirements
- R1: An access starts only when a dot-clock edge sees `bus_clk` high, with `bus_clk` low at the edge before and `req` high. The row step is visible after that same edge. `bus_clk` rising without `req` starts nothing.
- R2: In normal mode (`merge`=0) the steps are, one per dot cycle: row address; row address with `ras_n` low; column address with `ras_n` low; `cas_n` also low; a hold step with both strobes still low.
- R3: In merged mode (`merge`=1) the second step already shows the column address with `ras_n` low. The sequence is row, column+RAS, CAS, hold, which is one step shorter.
- R4: On the edge after the hold step, `ras_n`, `cas_n` and `we_n` all return high and `dq_oe` drops, all in the same cycle.
- R5: During reset and while idle, `ras_n`, `cas_n` and `we_n` are 1, and `dq_oe` and `rd_capture` are 0.
- R6: On a read, `rd_capture` is 1 for exactly the hold step, the step after `cas_n` first goes low. It stays 0 on writes.
- R7: The row half is `addr[ADDR_W-1:ADDR_W/2]` and the column half is `addr[ADDR_W/2-1:0]`. Both are presented on `dram_a`.
- R8: On a write (`wr`=1), `dq_oe` is 1 from the row step through the hold step and `dq_out` carries the write data latched at start. `we_n` is low from the column step through the hold step. On a read, `we_n` stays 1 and `dq_oe` stays 0.
- R9: While `bus_clk` is low, no control pin (`ras_n`, `cas_n`, `we_n`, `dq_oe`, `rd_capture`) changes and none is active.
- R10: A `req` raised while `bus_clk` is already high has no effect until the next rising edge of `bus_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dot | input | 1 | Fast dot clock that paces the steps |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | System bus clock, sampled as a level |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| merge | input | 1 | 1 = merge the RAS step with the column-address switch |
| addr | input | ADDR_W | Full DRAM address |
| wdata | input | DATA_W | Write data |
| dram_a | output | ADDR_W/2 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_oe | output | 1 | Data-output enable |
| dq_out | output | DATA_W | Write data toward the DRAM |
| rd_capture | output | 1 | Read-data capture strobe |

## Verification
The assertions assume that `bus_clk` changes only in step with the dot clock. They also assume that each high phase lasts at least one dot cycle longer than the longest sequence, so the release always comes before the bus clock falls. The bench drives `bus_clk` and every other input on falling dot-clock edges and holds each bus phase for eight dot cycles, which keeps the stimulus within both assumptions. `req` is dropped once the row step is seen, so each high phase carries at most one access.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_RAS  = 3'd2,
    S_COL  = 3'd3,
    S_CAS  = 3'd4,
    S_HOLD = 3'd5
  } seq_state_t;

  function automatic logic [9:0] upper_half10(input logic [19:0] a);
    return a[19:10];
  endfunction

  // RAS is low from the RAS step (or merged column step) to the hold step
  function automatic logic row_strobe_on(input seq_state_t s);
    return (s == S_RAS) || (s == S_COL) || (s == S_CAS) || (s == S_HOLD);
  endfunction

  function automatic logic col_strobe_on(input seq_state_t s);
    return (s == S_CAS) || (s == S_HOLD);
  endfunction

  function automatic logic col_addr_phase(input seq_state_t s);
    return (s == S_COL) || (s == S_CAS) || (s == S_HOLD);
  endfunction

  function automatic seq_state_t step_after(input seq_state_t s, input logic merged);
    case (s)
      S_ROW:   return merged ? S_COL : S_RAS;
      S_RAS:   return S_COL;
      S_COL:   return S_CAS;
      S_CAS:   return S_HOLD;
      default: return S_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/dss_start_detect.sv
module dss_start_detect (
  input  logic clk_dot,
  input  logic rst,
  input  logic bus_clk,
  input  logic req,
  output logic start
);
  logic bus_q;
  logic bus_rise;

  always_ff @(posedge clk_dot) begin
    if (rst) bus_q <= 1'b1;
    else     bus_q <= bus_clk;
  end

  assign bus_rise = bus_clk & ~bus_q;
  assign start    = bus_rise & req;

  a_r1_start_needs_low_before: assert property (@(posedge clk_dot) disable iff (rst)
    start |-> ($past(!bus_clk) || $past(rst)));
endmodule

// File: rtl/dss_seq_fsm.sv
module dss_seq_fsm #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                   clk_dot,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   wr,
  input  logic                   merge,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output dss_pkg::seq_state_t    state,
  output logic                   wr_q,
  output logic [ADDR_W-1:0]      addr_q,
  output logic [DATA_W-1:0]      wdata_q
);
  import dss_pkg::*;
  logic merge_q;
  logic take;

  assign take = (state == S_IDLE) && start;

  always_ff @(posedge clk_dot) begin
    if (rst) begin
      state   <= S_IDLE;
      wr_q    <= 1'b0;
      merge_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      state   <= S_ROW;
      wr_q    <= wr;
      merge_q <= merge;
      addr_q  <= addr;
      wdata_q <= wdata;
    end else if (state != S_IDLE) begin
      state <= step_after(state, merge_q);
    end
  end

  a_r3_merged_skips_ras: assert property (@(posedge clk_dot) disable iff (rst)
    (state == S_ROW && merge_q) |=> (state == S_COL));
  a_r2_normal_visits_ras: assert property (@(posedge clk_dot) disable iff (rst)
    (state == S_ROW && !merge_q) |=> (state == S_RAS));
endmodule

// File: rtl/dss_pin_drive.sv
module dss_pin_drive #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  dss_pkg::seq_state_t      state,
  input  logic                     wr_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [ADDR_W/2-1:0]      dram_a,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic                     dq_oe,
  output logic [DATA_W-1:0]        dq_out,
  output logic                     rd_capture
);
  import dss_pkg::*;
  localparam int HALF = ADDR_W / 2;

  logic [HALF-1:0] row_part;
  logic [HALF-1:0] col_part;
  logic            busy;

  generate
    if (ADDR_W == 20) begin : g_fn
      assign row_part = upper_half10(addr_q);
    end else begin : g_slice
      assign row_part = addr_q[ADDR_W-1:HALF];
    end
  endgenerate
  assign col_part = addr_q[HALF-1:0];
  assign busy     = (state != S_IDLE);

  always_comb begin
    dram_a     = col_addr_phase(state) ? col_part : row_part;
    ras_n      = !row_strobe_on(state);
    cas_n      = !col_strobe_on(state);
    we_n       = !(wr_q && col_addr_phase(state));
    dq_oe      = wr_q && busy;
    rd_capture = !wr_q && (state == S_HOLD);
    dq_out     = wdata_q;
  end
endmodule

// File: rtl/dram_step_seq.sv
module dram_step_seq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                   clk_dot,
  input  logic                   rst,
  input  logic                   bus_clk,
  input  logic                   req,
  input  logic                   wr,
  input  logic                   merge,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [ADDR_W/2-1:0]    dram_a,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   dq_oe,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   rd_capture
);
  import dss_pkg::*;

  logic              start_w;
  seq_state_t        state_w;
  logic              wr_w;
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] wdata_w;

  dss_start_detect u_start (
    .clk_dot(clk_dot), .rst(rst), .bus_clk(bus_clk), .req(req), .start(start_w)
  );

  dss_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_dot(clk_dot), .rst(rst), .start(start_w), .wr(wr), .merge(merge),
    .addr(addr), .wdata(wdata), .state(state_w), .wr_q(wr_w),
    .addr_q(addr_w), .wdata_q(wdata_w)
  );

  dss_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state_w), .wr_q(wr_w), .addr_q(addr_w), .wdata_q(wdata_w),
    .dram_a(dram_a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .rd_capture(rd_capture)
  );

  a_r5_idle_released: assert property (@(posedge clk_dot) disable iff (rst)
    (state_w == S_IDLE) |-> (ras_n && cas_n && we_n && !dq_oe && !rd_capture));
  a_r2_cas_after_ras: assert property (@(posedge clk_dot) disable iff (rst)
    $fell(cas_n) |-> (!ras_n && $past(!ras_n)));
  a_r4_release_together: assert property (@(posedge clk_dot) disable iff (rst)
    $rose(ras_n) |-> (cas_n && we_n && !dq_oe && $past(!cas_n)));
  a_r6_capture_inside_cas: assert property (@(posedge clk_dot) disable iff (rst)
    rd_capture |-> (!cas_n && $past(!cas_n) && we_n));
  a_r8_we_under_ras: assert property (@(posedge clk_dot) disable iff (rst)
    !we_n |-> (!ras_n && dq_oe));
  a_r9_quiet_bus_low: assert property (@(posedge clk_dot) disable iff (rst)
    !bus_clk |-> (ras_n && cas_n && we_n && !rd_capture));
endmodule

// File: tb/tb_dram_step_seq.sv
module tb_dram_step_seq;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int HW = AW / 2;

  logic clk = 1'b0;
  logic rst, bus_clk, req, wr, merge;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [HW-1:0] dram_a;
  logic ras_n, cas_n, we_n, dq_oe, rd_capture;
  logic [DW-1:0] dq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_step_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_dot(clk), .rst(rst), .bus_clk(bus_clk), .req(req), .wr(wr),
    .merge(merge), .addr(addr), .wdata(wdata), .dram_a(dram_a),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe),
    .dq_out(dq_out), .rd_capture(rd_capture)
  );

  // R9 monitor: pins frozen and inactive while bus_clk is low
  logic [4:0] prev_pins = 5'b11100;
  logic       monitor_on = 0;
  always @(negedge clk) begin
    #5;
    if (monitor_on && !bus_clk) begin
      if ({ras_n, cas_n, we_n, dq_oe, rd_capture} != prev_pins ||
          {ras_n, cas_n, we_n, rd_capture} != 4'b1110) begin
        bad++;
        $display("FAIL R9 pins=%b expected=%b while bus low",
                 {ras_n, cas_n, we_n, dq_oe, rd_capture}, 5'b11100);
      end
    end
    prev_pins = {ras_n, cas_n, we_n, dq_oe, rd_capture};
  end

  task automatic sample();
    @(negedge clk);
    #5;
  endtask

  task automatic check_pins(string tag, logic er, logic ec, logic ew, logic eo,
                            logic es, logic chk_a, logic [HW-1:0] ea);
    total++;
    if (ras_n !== er || cas_n !== ec || we_n !== ew || dq_oe !== eo ||
        rd_capture !== es || (chk_a && dram_a !== ea)) begin
      bad++;
      $display("FAIL %s got ras=%b cas=%b we=%b oe=%b cap=%b a=%h expected %b%b%b%b%b a=%h",
               tag, ras_n, cas_n, we_n, dq_oe, rd_capture, dram_a,
               er, ec, ew, eo, es, ea);
    end
  endtask

  task automatic bus_low_phase();
    @(negedge clk);
    bus_clk = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // one full access inside one bus-high phase; covers R1..R8
  task automatic run_access(logic [AW-1:0] a, logic w, logic [DW-1:0] d, logic m);
    logic [HW-1:0] rowv = HW'(a >> HW);
    logic [HW-1:0] colv = HW'(a % (1 << HW));
    logic nw = !w;
    int used = 0;
    @(negedge clk);
    addr = a; wr = w; wdata = d; merge = m; req = 1'b1; bus_clk = 1'b1;
    sample(); used++;
    req = 1'b0;
    check_pins("R1 R7 row step", 1, 1, 1, w, 0, 1, rowv);
    if (w) begin
      total++;
      if (dq_out !== d) begin
        bad++; $display("FAIL R8 dq_out=%h expected=%h", dq_out, d);
      end
    end
    if (!m) begin
      sample(); used++;
      check_pins("R2 ras step", 0, 1, 1, w, 0, 1, rowv);
    end
    sample(); used++;
    check_pins(m ? "R3 merged col+ras" : "R2 R7 col step", 0, 1, nw, w, 0, 1, colv);
    sample(); used++;
    check_pins("R2 cas step", 0, 0, nw, w, 0, 1, colv);
    sample(); used++;
    check_pins("R6 R8 hold step", 0, 0, nw, w, nw, 1, colv);
    sample(); used++;
    check_pins("R4 release", 1, 1, 1, 0, 0, 0, '0);
    repeat (7 - used) @(negedge clk);
    bus_low_phase();
  endtask

  // R1 R10: bus rises without req, req raised mid-high: nothing happens
  task automatic late_request();
    @(negedge clk);
    req = 1'b0; bus_clk = 1'b1; wr = 1'b1;
    sample();
    check_pins("R1 rise without req", 1, 1, 1, 0, 0, 0, '0);
    req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sample();
      check_pins("R10 req while high", 1, 1, 1, 0, 0, 0, '0);
    end
    @(negedge clk);
    req = 1'b0;
    bus_low_phase();
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_clk = 0; req = 0; wr = 0; merge = 0; addr = '0; wdata = '0;
    repeat (3) sample();
    check_pins("R5 during reset", 1, 1, 1, 0, 0, 0, '0);
    @(negedge clk); rst = 0;
    sample();
    check_pins("R5 idle after reset", 1, 1, 1, 0, 0, 0, '0);
    monitor_on = 1;
    repeat (4) @(negedge clk);
    run_access(20'hABCDE, 1'b0, 8'h00, 1'b0);
    run_access(20'h12345, 1'b1, 8'h5A, 1'b0);
    run_access(20'hFFC01, 1'b0, 8'h00, 1'b1);
    run_access(20'h003FF, 1'b1, 8'hC3, 1'b1);
    late_request();
    run_access(20'h80200, 1'b1, 8'h81, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule